// File: doc/BRIEF.md
# Pulse Accumulator Bank with Snapshot Registers

This block holds four 8-bit edge counters. Each one counts the qualifying transitions on its own pulse input. The qualifying transition is chosen per channel and can be the rising edge, the falling edge, both edges, or none. Every counter has a snapshot register. On a shared strobe, which is typically the zero event of a periodic down-counter elsewhere in the chip, the snapshot register takes the counter's value. The strobe can also restart the counter from zero. Used that way, each snapshot holds the number of edges seen in one period.

Neighbouring channels form pairs (0 with 1, 2 with 3). When a pair is set to cascade, the even channel becomes the low byte of a 16-bit counter and the odd channel becomes its high byte. Both snapshot registers of the pair are loaded in the same cycle. A registered read port returns any channel's running count or snapshot one clock after the address is applied.

Top module: `pulse_hold_accum`

## Requirements
- R1: While `rst` is high at a clock edge, every counter and every snapshot register is set to zero, and so is `rd_data`.
- R2: Each channel uses a 2-bit mode code: 00 counts nothing, 01 counts rising edges, 10 counts falling edges, 11 counts both. The input level is compared with its level at the previous clock edge. A qualifying change adds one to the counter at the clock edge where the change is first sampled.
- R3: An uncascaded counter wraps from 255 to 0.
- R4: At a clock edge where `latch_strobe` is high, each snapshot register takes the counter value from before that edge. When `clear_on_latch` is low, counting continues without a break.
- R5: At a strobe with `clear_on_latch` high, the counter restarts at 0. If a qualifying edge occurs in that same cycle, the counter restarts at 1 instead.
- R6: When bit p of `pair_cascade` is set, channel 2p counts its own input as the low byte. Channel 2p+1 adds one only when the low byte wraps from 255. The input of channel 2p+1 has no effect.
- R7: In a cascaded pair, one strobe loads both snapshot registers from the same edge, so together they hold the full 16-bit count.
- R8: `rd_data` shows, one clock later, the register that `rd_addr` and `rd_hold` select. `rd_hold` = 0 selects the running count and 1 selects the snapshot.
- R9: A snapshot register keeps its value in every cycle without a strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pulse_in | input | 4 | Pulse inputs, one per channel, synchronous to `clk` |
| edge_mode | input | 8 | 2-bit edge mode per channel; channel n uses bits [2n+1:2n] |
| pair_cascade | input | 2 | Bit p joins channels 2p and 2p+1 into one 16-bit counter |
| latch_strobe | input | 1 | Single-cycle snapshot strobe |
| clear_on_latch | input | 1 | Restart the counters when the strobe fires |
| rd_addr | input | 2 | Channel to read |
| rd_hold | input | 1 | 0 reads the running count, 1 reads the snapshot |
| rd_data | output | 8 | Registered read data |

## Verification
The assertions assume that `pulse_in` is already synchronous to `clk`. They also assume that `latch_strobe` and the read selectors are stable around each rising edge. The bench meets this by changing every input only on the falling clock edge, and it keeps every pulse at least one full cycle high and one full cycle low. The bench leaves the mode and cascade settings unchanged while pulses are applied. Any edge that a setting change could create or lose therefore falls outside the checked windows.

// File: rtl/pha_pkg.sv
package pha_pkg;
  typedef enum logic [1:0] {
    EDGE_NONE = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_BOTH = 2'b11
  } edge_mode_e;
endpackage

// File: rtl/pha_edge_detect.sv
module pha_edge_detect
  import pha_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       pin,
  input  logic [1:0] mode,
  output logic       hit
);
  logic prev_q;

  always_ff @(posedge clk) begin
    prev_q <= pin;
  end

  always_comb begin
    unique case (edge_mode_e'(mode))
      EDGE_RISE: hit = pin & ~prev_q;
      EDGE_FALL: hit = ~pin & prev_q;
      EDGE_BOTH: hit = pin ^ prev_q;
      default:   hit = 1'b0;
    endcase
    if (rst) hit = 1'b0;
  end
endmodule

// File: rtl/pha_pair.sv
module pha_pair #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hit_lo,
  input  logic             hit_hi,
  input  logic             cascade,
  input  logic             latch,
  input  logic             clr,
  output logic [CNT_W-1:0] cnt_lo,
  output logic [CNT_W-1:0] cnt_hi,
  output logic [CNT_W-1:0] hold_lo,
  output logic [CNT_W-1:0] hold_hi
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic inc_lo, inc_hi;

  assign inc_lo = hit_lo;
  assign inc_hi = cascade ? (hit_lo && cnt_lo == CNT_MAX) : hit_hi;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_lo  <= '0;
      cnt_hi  <= '0;
      hold_lo <= '0;
      hold_hi <= '0;
    end else begin
      if (latch) begin
        hold_lo <= cnt_lo;
        hold_hi <= cnt_hi;
      end
      if (latch && clr) begin
        cnt_lo <= CNT_W'(inc_lo);
        cnt_hi <= cascade ? '0 : CNT_W'(inc_hi);
      end else begin
        cnt_lo <= cnt_lo + CNT_W'(inc_lo);
        cnt_hi <= cnt_hi + CNT_W'(inc_hi);
      end
    end
  end
endmodule

// File: rtl/pulse_hold_accum.sv
module pulse_hold_accum #(
  parameter int NUM_CH = 4,
  parameter int CNT_W  = 8,
  localparam int NUM_PAIR = NUM_CH / 2,
  localparam int IDX_W    = $clog2(NUM_CH)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_CH-1:0]   pulse_in,
  input  logic [2*NUM_CH-1:0] edge_mode,
  input  logic [NUM_PAIR-1:0] pair_cascade,
  input  logic                latch_strobe,
  input  logic                clear_on_latch,
  input  logic [IDX_W-1:0]    rd_addr,
  input  logic                rd_hold,
  output logic [CNT_W-1:0]    rd_data
);
  logic [NUM_CH-1:0]       hit;
  logic [NUM_CH*CNT_W-1:0] cnt_flat;
  logic [NUM_CH*CNT_W-1:0] hold_flat;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_edge
    pha_edge_detect u_edge (
      .clk  (clk),
      .rst  (rst),
      .pin  (pulse_in[c]),
      .mode (edge_mode[2*c +: 2]),
      .hit  (hit[c])
    );
  end

  for (genvar p = 0; p < NUM_PAIR; p++) begin : g_pair
    pha_pair #(.CNT_W(CNT_W)) u_pair (
      .clk     (clk),
      .rst     (rst),
      .hit_lo  (hit[2*p]),
      .hit_hi  (hit[2*p+1]),
      .cascade (pair_cascade[p]),
      .latch   (latch_strobe),
      .clr     (clear_on_latch),
      .cnt_lo  (cnt_flat[(2*p)*CNT_W +: CNT_W]),
      .cnt_hi  (cnt_flat[(2*p+1)*CNT_W +: CNT_W]),
      .hold_lo (hold_flat[(2*p)*CNT_W +: CNT_W]),
      .hold_hi (hold_flat[(2*p+1)*CNT_W +: CNT_W])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else if (rd_hold) rd_data <= hold_flat[rd_addr*CNT_W +: CNT_W];
    else rd_data <= cnt_flat[rd_addr*CNT_W +: CNT_W];
  end
endmodule

// File: rtl/pha_checker.sv
module pha_checker #(
  parameter int NUM_CH = 4,
  parameter int CNT_W  = 8,
  localparam int IDX_W = $clog2(NUM_CH)
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    latch_strobe,
  input logic [IDX_W-1:0]        rd_addr,
  input logic                    rd_hold,
  input logic [CNT_W-1:0]        rd_data,
  input logic [NUM_CH*CNT_W-1:0] cnt_flat,
  input logic [NUM_CH*CNT_W-1:0] hold_flat
);
  // R1
  reset_clears_chk: assert property (@(posedge clk)
    rst |=> (cnt_flat == '0 && hold_flat == '0 && rd_data == '0));

  // R4
  snapshot_load_chk: assert property (@(posedge clk) disable iff (rst)
    latch_strobe |=> hold_flat == $past(cnt_flat));

  // R9
  snapshot_keep_chk: assert property (@(posedge clk) disable iff (rst)
    !latch_strobe |=> $stable(hold_flat));

  // R8
  read_count_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_hold |=> rd_data == $past(cnt_flat[rd_addr*CNT_W +: CNT_W]));

  // R8
  read_hold_chk: assert property (@(posedge clk) disable iff (rst)
    rd_hold |=> rd_data == $past(hold_flat[rd_addr*CNT_W +: CNT_W]));
endmodule

bind pulse_hold_accum pha_checker #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .latch_strobe (latch_strobe),
  .rd_addr      (rd_addr),
  .rd_hold      (rd_hold),
  .rd_data      (rd_data),
  .cnt_flat     (cnt_flat),
  .hold_flat    (hold_flat)
);

// File: tb/pulse_hold_accum_test.sv
`timescale 1ns/1ps
module pulse_hold_accum_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] pulse_in = '0;
  logic [7:0] edge_mode = '0;
  logic [1:0] pair_cascade = '0;
  logic       latch_strobe = 1'b0;
  logic       clear_on_latch = 1'b0;
  logic [1:0] rd_addr = '0;
  logic       rd_hold = 1'b0;
  logic [7:0] rd_data;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pulse_hold_accum uut (
    .clk(clk), .rst(rst), .pulse_in(pulse_in), .edge_mode(edge_mode),
    .pair_cascade(pair_cascade), .latch_strobe(latch_strobe),
    .clear_on_latch(clear_on_latch), .rd_addr(rd_addr), .rd_hold(rd_hold),
    .rd_data(rd_data)
  );

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic read_reg(input int ch, input bit hold, output logic [7:0] v);
    @(negedge clk);
    rd_addr = 2'(ch);
    rd_hold = hold;
    @(posedge clk);
    #1 v = rd_data;
  endtask

  task automatic expect_reg(string req, int ch, bit hold, logic [7:0] exp);
    logic [7:0] v;
    read_reg(ch, hold, v);
    check(req, v, exp);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    pulse_in = '0;
    latch_strobe = 1'b0;
    clear_on_latch = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic pulses(logic [3:0] mask, int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) pulse_in = pulse_in | mask;
      @(negedge clk) pulse_in = pulse_in & ~mask;
    end
  endtask

  task automatic strobe(bit clr);
    @(negedge clk);
    latch_strobe = 1'b1;
    clear_on_latch = clr;
    @(negedge clk);
    latch_strobe = 1'b0;
    clear_on_latch = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    for (int c = 0; c < 4; c++) begin
      expect_reg("R1 count", c, 1'b0, 8'd0);
      expect_reg("R1 hold", c, 1'b1, 8'd0);
    end
  endtask

  task automatic t_modes();
    do_reset();
    edge_mode = {2'b00, 2'b11, 2'b10, 2'b01};
    pulses(4'b1111, 3);
    expect_reg("R2 rising", 0, 1'b0, 8'd3);
    expect_reg("R2 falling", 1, 1'b0, 8'd3);
    expect_reg("R2 both", 2, 1'b0, 8'd6);
    expect_reg("R2 none", 3, 1'b0, 8'd0);
  endtask

  task automatic t_wrap();
    do_reset();
    edge_mode = 8'h55;
    pulses(4'b0001, 255);
    expect_reg("R3 top", 0, 1'b0, 8'd255);
    pulses(4'b0001, 2);
    expect_reg("R3 wrap", 0, 1'b0, 8'd1);
    expect_reg("R3 neighbour", 1, 1'b0, 8'd0);
  endtask

  task automatic t_latch();
    do_reset();
    edge_mode = 8'h55;
    pulses(4'b0001, 5);
    strobe(1'b0);
    expect_reg("R4 hold", 0, 1'b1, 8'd5);
    expect_reg("R4 count kept", 0, 1'b0, 8'd5);
    pulses(4'b0001, 2);
    expect_reg("R9 hold kept", 0, 1'b1, 8'd5);
    expect_reg("R4 count on", 0, 1'b0, 8'd7);
    strobe(1'b1);
    expect_reg("R5 hold", 0, 1'b1, 8'd7);
    expect_reg("R5 cleared", 0, 1'b0, 8'd0);
    pulses(4'b0001, 4);
    @(negedge clk);
    pulse_in[0] = 1'b1;
    latch_strobe = 1'b1;
    clear_on_latch = 1'b1;
    @(negedge clk);
    latch_strobe = 1'b0;
    clear_on_latch = 1'b0;
    pulse_in[0] = 1'b0;
    expect_reg("R5 coincident hold", 0, 1'b1, 8'd4);
    expect_reg("R5 coincident count", 0, 1'b0, 8'd1);
  endtask

  task automatic t_cascade();
    do_reset();
    edge_mode = 8'h55;
    pair_cascade = 2'b01;
    pulses(4'b0001, 300);
    pulses(4'b0010, 5);
    expect_reg("R6 low", 0, 1'b0, 8'd44);
    expect_reg("R6 high", 1, 1'b0, 8'd1);
    strobe(1'b0);
    expect_reg("R7 hold low", 0, 1'b1, 8'd44);
    expect_reg("R7 hold high", 1, 1'b1, 8'd1);
    strobe(1'b1);
    expect_reg("R7 clear low", 0, 1'b0, 8'd0);
    expect_reg("R7 clear high", 1, 1'b0, 8'd0);
    pair_cascade = 2'b00;
  endtask

  initial begin
    t_reset();
    t_modes();
    t_wrap();
    t_latch();
    t_cascade();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule